// File: doc/BRIEF.md
# Repeating Successive-Approximation Conversion Sequencer

This block is the digital half of an eight-input successive-approximation analog-to-digital converter. Software drives it through a small write port that reaches two registers. The control register holds an enable flag, a trigger-source flag and a go flag. The channel register picks one of the eight inputs. While running, the block sends a trial code to an external DAC and reads back a single comparator bit. It resolves the code one bit per clock, starting at the MSB. It then stores the finished value and pulses an interrupt for one cycle.

Once started, the sequencer goes straight into another conversion of the same input, with no further action from software. A register write that arrives mid-conversion changes what happens next. A channel write, or a control write that keeps the go flag set, throws away the partial code and starts again from the sampling phase. A control write that clears the go flag halts the sequencer on the next edge. The stored result is then not refreshed.

Top module: `sar_seq_top`

## Requirements
- R1: The control register is written when `wr_sel` is 0. Its fields are: `wr_data[0]` enable, `wr_data[6]` trigger source (1 selects hardware triggering, which this block does not run, so it stays idle) and `wr_data[7]` go. The channel register is written when `wr_sel` is 1 and takes its value from `wr_data[2:0]`.
- R2: Conversion starts only from a control write with go=1 and trigger source=0, and only when enable was already 1 before that write. The first `done_irq` is seen 14 cycles after the write edge.
- R3: `chan_sel` reflects the channel register (0 to 7), and each result is the conversion of that input.
- R4: On completion, `result` is loaded and `done_irq` is high for exactly one cycle.
- R5: With no further writes, completions repeat every 14 cycles on the same channel.
- R6: Any mode or channel write during a conversion discards it without loading `result` or raising `done_irq`. It then restarts on the newly written settings, and the next `done_irq` comes 14 cycles after that write.
- R7: Writing go=1 again while running restarts the conversion from the sampling phase, with the next `done_irq` 14 cycles after the write.
- R8: A control write with go=0 stops the sequencer by the next cycle: `busy` is 0, `dac_code` is 0 and no `done_irq` follows.
- R9: While enable is 0 the sequencer stays idle and a go write has no effect.
- R10: Each conversion is 4 sampling cycles (with `dac_code` = 0) followed by 10 decision cycles, MSB first. The trial code is the decided bits with the current bit set. The bit is kept when `cmp_in` = 1, which means the input is at or above `dac_code`.
- R11: `result` keeps its last loaded value until the next completion, including across stops and aborts.
- R12: After reset, `result`, `dac_code`, `done_irq` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = channel register |
| wr_data | input | 8 | Write data |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code to the DAC |
| chan_sel | output | 3 | Selected analog input |
| busy | output | 1 | Sequencer is sampling or converting |
| done_irq | output | 1 | One-cycle completion pulse |
| result | output | 10 | Last stored conversion result |

## Verification
The bench targets four corner cases.

- Writes that land mid-conversion. If a design ignored them, `done_irq` would arrive before the expected 14-cycle latency measured from the write. If a design stored the aborted value, `result` would change with no pulse.
- Stopping with go=0. A design that finished the conversion in flight would still emit a pulse and overwrite `result`.
- Go writes while disabled, and the hardware-trigger setting. A design that ignored the enable or trigger-source qualification would start converting.
- Full-scale inputs (0 and 1023) and codes either side of the MSB boundary. These expose an off-by-one in the bit walk or in the comparator polarity.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W      = 10;
    localparam int CH_NUM     = 8;
    localparam int CH_W       = $clog2(CH_NUM);
    localparam int DATA_W     = 8;
    localparam int SAMPLE_CYC = 4;

    localparam int CTL_EN_POS  = 0;
    localparam int CTL_HW_POS  = 6;
    localparam int CTL_GO_POS  = 7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } sar_state_e;

    typedef enum logic {
        SEL_CTL  = 1'b0,
        SEL_CHAN = 1'b1
    } wr_sel_e;

    typedef struct packed {
        logic go;
        logic hw_trig;
        logic enable;
    } ctl_t;

    function automatic ctl_t unpack_ctl(input logic [DATA_W-1:0] d);
        ctl_t c;
        c.enable  = d[CTL_EN_POS];
        c.hw_trig = d[CTL_HW_POS];
        c.go      = d[CTL_GO_POS];
        return c;
    endfunction

    function automatic logic sw_running(input ctl_t c);
        return c.enable & ~c.hw_trig & c.go;
    endfunction

endpackage

// File: rtl/sar_seq_regs.sv
module sar_seq_regs
    import sar_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              run_next_o,
    output logic              restart_o
);

    ctl_t            ctl_q, ctl_d;
    logic [CH_W-1:0] chan_q, chan_d;

    always_comb begin
        ctl_d  = ctl_q;
        chan_d = chan_q;
        if (wr_en) begin
            if (wr_sel_e'(wr_sel) == SEL_CTL) begin
                ctl_d    = unpack_ctl(wr_data);
                // go is only accepted when enable was set beforehand
                ctl_d.go = ctl_d.go & ctl_q.enable;
            end else begin
                chan_d = wr_data[CH_W-1:0];
            end
        end
    end

    assign run_next_o = sw_running(ctl_d);
    assign restart_o  = wr_en & run_next_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            chan_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            chan_q <= chan_d;
        end
    end

    assign ctl_o  = ctl_q;
    assign chan_o = chan_q;

    AST_GO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.enable && wr_en && wr_sel == 1'b0) |=> !ctl_q.go); // R9

endmodule

// File: rtl/sar_seq_engine.sv
module sar_seq_engine
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS   = RES_W,
    parameter int SMP_CYCLES = SAMPLE_CYC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_i,
    input  logic                restart_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] dac_o,
    output logic                busy_o,
    output logic                irq_o,
    output logic                load_o,
    output logic [RES_BITS-1:0] value_o
);

    localparam int CNT_W = (SMP_CYCLES > 1) ? $clog2(SMP_CYCLES) : 1;
    localparam int IDX_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SMP_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES_BITS - 1);

    sar_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [IDX_W-1:0]    idx_q;
    logic [RES_BITS-1:0] acc_q;
    logic                irq_q;

    logic [RES_BITS-1:0] trial;
    logic [RES_BITS-1:0] decided;
    logic                finish;

    always_comb begin
        trial   = acc_q | (RES_BITS'(1) << idx_q);
        decided = cmp_i ? trial : acc_q;
        finish  = (state_q == ST_CONV) && (idx_q == '0) && run_i && !restart_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            acc_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= finish;
            if (!run_i) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
                idx_q   <= '0;
                acc_q   <= '0;
            end else if (restart_i || state_q == ST_IDLE) begin
                state_q <= ST_SAMPLE;
                cnt_q   <= '0;
                idx_q   <= '0;
                acc_q   <= '0;
            end else begin
                unique case (state_q)
                    ST_SAMPLE: begin
                        if (cnt_q == CNT_LAST) begin
                            state_q <= ST_CONV;
                            idx_q   <= IDX_TOP;
                            acc_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_CONV: begin
                        acc_q <= decided;
                        if (idx_q == '0) begin
                            state_q <= ST_SAMPLE;
                            cnt_q   <= '0;
                        end else begin
                            idx_q <= idx_q - 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign dac_o   = (state_q == ST_CONV) ? trial : '0;
    assign busy_o  = (state_q != ST_IDLE);
    assign irq_o   = irq_q;
    assign load_o  = finish;
    assign value_o = decided;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q); // R4

    AST_STOP_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (state_q == ST_IDLE && !irq_q)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (dac_o == '0 && !irq_q)); // R8

    AST_RESTART_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        (restart_i && run_i) |=> (state_q == ST_SAMPLE && cnt_q == '0 && !irq_q)); // R6

    AST_SAMPLE_THEN_MSB: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAMPLE && cnt_q == CNT_LAST && run_i && !restart_i)
        |=> (state_q == ST_CONV && idx_q == IDX_TOP)); // R10

endmodule

// File: rtl/sar_seq_result.sv
module sar_seq_result
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = RES_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [RES_BITS-1:0] value_i,
    output logic [RES_BITS-1:0] result_o
);

    logic [RES_BITS-1:0] result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (load_i) begin
            result_q <= value_i;
        end
    end

    assign result_o = result_q;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(result_q)); // R11

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS   = RES_W,
    parameter int SMP_CYCLES = SAMPLE_CYC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic [CH_W-1:0]     chan_sel,
    output logic                busy,
    output logic                done_irq,
    output logic [RES_BITS-1:0] result
);

    ctl_t                ctl;
    logic                run_next;
    logic                restart;
    logic                load;
    logic [RES_BITS-1:0] value;

    sar_seq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ctl_o      (ctl),
        .chan_o     (chan_sel),
        .run_next_o (run_next),
        .restart_o  (restart)
    );

    sar_seq_engine #(
        .RES_BITS   (RES_BITS),
        .SMP_CYCLES (SMP_CYCLES)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_next),
        .restart_i (restart),
        .cmp_i     (cmp_in),
        .dac_o     (dac_code),
        .busy_o    (busy),
        .irq_o     (done_irq),
        .load_o    (load),
        .value_o   (value)
    );

    sar_seq_result #(
        .RES_BITS (RES_BITS)
    ) u_result (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .value_i  (value),
        .result_o (result)
    );

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ctl.enable |-> !busy); // R9

    AST_HW_TRIG_IDLE: assert property (@(posedge clk) disable iff (rst)
        ctl.hw_trig |-> !busy); // R1

endmodule

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 14;
    localparam int NVEC       = 6;

    // {channel, analog code}
    localparam logic [12:0] VEC [NVEC] = '{
        {3'd3, 10'd0},
        {3'd7, 10'd1023},
        {3'd0, 10'd512},
        {3'd5, 10'd511},
        {3'd1, 10'd341},
        {3'd6, 10'd682}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [2:0] chan_sel;
    logic       busy;
    logic       done_irq;
    logic [9:0] result;

    logic [9:0] ana [8];

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_in = (ana[chan_sel] >= dac_code);

    sar_seq_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .chan_sel (chan_sel),
        .busy     (busy),
        .done_irq (done_irq),
        .result   (result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_irq(output int lat);
        lat = -1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (done_irq) begin
                lat = i;
                break;
            end
        end
    endtask

    task automatic quiet(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy || done_irq) hits++;
        end
    endtask

    initial begin
        int lat;
        int hits;
        logic [9:0] r0;
        for (int c = 0; c < 8; c++) ana[c] = 10'd0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(result == 0 && dac_code == 0 && !done_irq && !busy, "R12",
              int'({result, dac_code, done_irq, busy}), 0);

        // R9: go write while disabled does nothing
        wr(1'b0, 8'h80);
        quiet(30, hits);
        check(hits == 0, "R9", hits, 0);

        // R1: enable, then go with hardware-trigger source set stays idle
        wr(1'b0, 8'h01);
        wr(1'b0, 8'hC1);
        quiet(30, hits);
        check(hits == 0, "R1", hits, 0);

        // R2 / R10: software start on channel 2, walk the timeline
        ana[2] = 10'd700;
        wr(1'b1, 8'h02);
        check(chan_sel == 3'd2, "R3", chan_sel, 2);
        wr(1'b0, 8'h81);
        hits = 0;
        for (int i = 1; i <= LAT; i++) begin
            @(negedge clk);
            if (i < LAT && done_irq) hits++;
            if (i == 3) check(busy && dac_code == 0, "R10 sampling", dac_code, 0);
            if (i == 4) check(dac_code == 10'd512, "R10 msb trial", dac_code, 512);
            if (i == 5) check(dac_code == 10'd768, "R10 second trial", dac_code, 768);
            if (i == LAT) begin
                check(done_irq && hits == 0, "R2 latency", hits, 0);
                check(result == 10'd700, "R4 result", result, 700);
            end
        end

        // R5: repeats with no software action, R4 one-cycle pulse
        wait_irq(lat);
        check(lat == LAT, "R5 period", lat, LAT);
        @(negedge clk);
        check(!done_irq, "R4 pulse width", done_irq, 0);

        // R3 / R6: vector table, each channel write lands mid-conversion
        for (int v = 0; v < NVEC; v++) begin
            ana[VEC[v][12:10]] = VEC[v][9:0];
            wr(1'b1, {5'd0, VEC[v][12:10]});
            wait_irq(lat);
            check(lat == LAT, "R6 restart latency", lat, LAT);
            check(result == VEC[v][9:0], "R3 channel result", result, VEC[v][9:0]);
        end

        // R7: rewrite go mid-conversion restarts from sampling
        repeat (6) @(negedge clk);
        wr(1'b0, 8'h81);
        wait_irq(lat);
        check(lat == LAT, "R7 restart latency", lat, LAT);

        // R6: aborted conversion stores nothing
        ana[4] = 10'd99;
        repeat (9) @(negedge clk);
        r0 = result;
        wr(1'b1, 8'h04);
        hits = 0;
        for (int i = 1; i < LAT; i++) begin
            @(negedge clk);
            if (done_irq || result != r0) hits++;
        end
        check(hits == 0, "R6 no store on abort", hits, 0);
        @(negedge clk);
        check(done_irq && result == 10'd99, "R6 new channel", result, 99);

        // R8 / R11: clear go mid-conversion
        repeat (5) @(negedge clk);
        r0 = result;
        wr(1'b0, 8'h01);
        check(!busy && dac_code == 0, "R8 immediate stop", int'(busy), 0);
        quiet(40, hits);
        check(hits == 0, "R8 no pulse after stop", hits, 0);
        check(result == r0, "R11 result held", result, r0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule